// File: doc/BRIEF.md
# Configuration Frame Snapshot Formatter

This block sits between a configuration-memory access port and a snapshot store. It is used to suspend a tenant design, save its state and later put that state back. On the save side it receives the word stream that a frame readback produces. Each readback returns one frame of dummy words followed by the real frame. The block throws the dummy frame away and passes the real words to a storage write port. Each stored word carries its position in the frame and the frame address that was presented with the first word of that readback.

On the restore side the block is started once per frame. It pulls the saved words from a storage read port and emits them, and it changes the words as it goes: for frames the caller marks as block-RAM frames, selected bits of selected words are cleared. These are bits that always read back as set and would otherwise restore stale contents. After the data words it emits a frame of zero words. It then ends with one command word that resets the checksum, so that no checksum has to be recomputed.

A small sequencer controls the tenant's clock. A halt request stops the tenant clock, and readback or writeback traffic is accepted only while that clock is off. A resume request, taken only when no frame is partway through, raises a global set/reset pulse for a fixed number of cycles. The clock is enabled again only after that pulse has ended.

Top module: `cfg_snap_fmt`

## Requirements
- R1: After reset the tenant clock enable is high, the set/reset pulse is low, readback ready is low, and neither the storage write valid nor the writeback valid is asserted.
- R2: A halt request while the tenant clock is running drives the clock enable low on the next cycle. While the clock runs, readback words are not accepted (ready low, no storage write).
- R3: A readback frame is exactly 2×FRAME_WORDS accepted words. The first FRAME_WORDS words are dropped. Each of the next FRAME_WORDS words is presented unchanged on the storage port, with index 0 to FRAME_WORDS-1 in arrival order.
- R4: Every stored word of a frame carries the frame address that was on the address input when the frame's first word was accepted. Later changes to that input have no effect on it.
- R5: The readback done pulse is high exactly with the acceptance of a frame's final word, and the next accepted word begins a new frame at index 0.
- R6: Dropped words are accepted whatever the storage ready is. Data words are accepted only while storage ready is high.
- R7: A writeback started while the clock is off emits exactly 2×FRAME_WORDS+1 words: the FRAME_WORDS loaded words, then FRAME_WORDS zero words, then CRC_RST_WORD (default 32'hC0DE_0007). The done pulse coincides with the transfer of the last of these.
- R8: If the block-RAM flag is high when a writeback starts, loaded word i is emitted as data AND NOT FIX_MASK when i mod FIX_STRIDE equals FIX_PHASE (defaults 32'h0003_0000, 4, 1). Every other word, and every word when the flag is low, is emitted unchanged.
- R9: While the writeback ready is low, no loaded word is consumed and the emitted word is held.
- R10: A resume request while the clock is off and no frame is in progress raises the set/reset pulse for GSR_LEN cycles, with the clock enable still low. The clock enable rises in the cycle after the pulse falls, and the two are never high together.
- R11: A resume request is ignored while a readback or writeback frame is partly done. A writeback start is ignored while the tenant clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Request to stop the tenant clock |
| resume_req | input | 1 | Request to restart the tenant after restore |
| tenant_clk_en | output | 1 | Tenant clock enable |
| gsr_pulse | output | 1 | Global set/reset strobe |
| rb_valid | input | 1 | Readback word valid |
| rb_ready | output | 1 | Readback word accepted |
| rb_data | input | WORD_W | Readback word |
| rb_frame_addr | input | FAR_W | Frame address, sampled with a frame's first word |
| rb_frame_done | output | 1 | Last word of a readback frame accepted |
| st_valid | output | 1 | Storage write valid |
| st_ready | input | 1 | Storage can take a word |
| st_data | output | WORD_W | Storage write data |
| st_idx | output | IDX_W | Word position within the frame |
| st_addr | output | FAR_W | Frame address tag |
| wb_start | input | 1 | Begin one writeback frame |
| wb_brm | input | 1 | Frame is a block-RAM frame (sampled at start) |
| ld_valid | input | 1 | Stored word available |
| ld_ready | output | 1 | Stored word consumed |
| ld_data | input | WORD_W | Stored word |
| wb_valid | output | 1 | Writeback word valid |
| wb_ready | input | 1 | Writeback word taken |
| wb_data | output | WORD_W | Writeback word |
| wb_frame_done | output | 1 | Final writeback word transferred |

## Verification
Some rules are checked by the assertions on every cycle: the clock is off whenever a readback word is accepted, clock enable and set/reset are never both high, the clock follows the fall of the pulse, a blocked resume leaves the pulse low, the frame tag stays stable within a frame, stalled pad or command words are held, and no stored word is taken without output ready. Other behaviour can only be shown by the bench's scenarios. That covers the word counts and positions in both stream layouts, the exact bit patching of block-RAM frames against plain frames, the length of the pulse, and the restart of indexing on a second frame.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic [1:0] {
    SQ_RUN,
    SQ_FROZEN,
    SQ_GSR
  } seq_st_e;

  typedef enum logic [1:0] {
    EM_IDLE,
    EM_DATA,
    EM_PAD,
    EM_CMD
  } emit_ph_e;

  // Selects which word positions of a block-RAM frame are patched.
  function automatic logic word_patched(input int idx, input int stride, input int phase);
    return (idx % stride) == phase;
  endfunction

  // Words in one readback transfer: dummy frame plus real frame.
  function automatic int rb_words(input int frame_words);
    return 2 * frame_words;
  endfunction

endpackage

// File: rtl/snap_clk_seq.sv
module snap_clk_seq #(
  parameter int GSR_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic resume_req,
  input  logic busy,
  output logic frozen,
  output logic tenant_clk_en,
  output logic gsr_pulse
);
  import snap_pkg::*;

  localparam int GW = $clog2(GSR_LEN + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GSR_LEN - 1);

  seq_st_e st;
  logic [GW-1:0] gcnt;
  logic resume_ok;

  assign resume_ok     = (st == SQ_FROZEN) && resume_req && !busy;
  assign frozen        = (st == SQ_FROZEN);
  assign tenant_clk_en = (st == SQ_RUN);
  assign gsr_pulse     = (st == SQ_GSR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_RUN;
      gcnt <= '0;
    end else begin
      case (st)
        SQ_RUN:    if (halt_req) st <= SQ_FROZEN;
        SQ_FROZEN: if (resume_ok) begin
          st   <= SQ_GSR;
          gcnt <= '0;
        end
        SQ_GSR: begin
          if (gcnt == G_LAST) st <= SQ_RUN;
          else gcnt <= gcnt + 1'b1;
        end
        default: st <= SQ_RUN;
      endcase
    end
  end

  a_r2_halt_stops_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (tenant_clk_en && halt_req) |=> !tenant_clk_en);
  a_r10_no_clock_in_gsr: assert property (@(posedge clk) disable iff (!rst_n)
    !(tenant_clk_en && gsr_pulse));
  a_r10_clock_after_gsr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gsr_pulse) |-> tenant_clk_en);
  a_r11_busy_blocks_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && busy) |=> !gsr_pulse);

endmodule

// File: rtl/snap_capture.sv
module snap_capture #(
  parameter int WORD_W      = 32,
  parameter int FAR_W       = 32,
  parameter int FRAME_WORDS = 101,
  parameter int IDX_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [WORD_W-1:0] rb_data,
  input  logic [FAR_W-1:0]  rb_frame_addr,
  output logic              rb_frame_done,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_data,
  output logic [IDX_W-1:0]  st_idx,
  output logic [FAR_W-1:0]  st_addr,
  output logic              busy
);
  localparam int TOTAL = snap_pkg::rb_words(FRAME_WORDS);
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] DATA_FIRST = CW'(FRAME_WORDS);
  localparam logic [CW-1:0] LAST_WORD  = CW'(TOTAL - 1);

  logic [CW-1:0]    cnt;
  logic [FAR_W-1:0] far_q;
  logic             in_data;
  logic             at_last;
  logic             accept;

  assign in_data  = (cnt >= DATA_FIRST);
  assign at_last  = (cnt == LAST_WORD);
  assign rb_ready = frozen && (!in_data || st_ready);
  assign accept   = rb_valid && rb_ready;

  assign st_valid      = frozen && rb_valid && in_data;
  assign st_data       = rb_data;
  assign st_idx        = IDX_W'(cnt - DATA_FIRST);
  assign st_addr       = far_q;
  assign rb_frame_done = accept && at_last;
  assign busy          = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      far_q <= '0;
    end else if (accept) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
      if (cnt == '0) far_q <= rb_frame_addr;
    end
  end

  a_r2_accept_only_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_ready) |-> frozen);
  a_r5_done_is_store: assert property (@(posedge clk) disable iff (!rst_n)
    rb_frame_done |-> (st_valid && st_ready));
  a_r4_tag_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_idx != '0) |-> $stable(st_addr));
  a_r6_data_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> !rb_ready);

endmodule

// File: rtl/snap_emit.sv
module snap_emit #(
  parameter int                WORD_W       = 32,
  parameter int                FRAME_WORDS  = 101,
  parameter int                IDX_W        = 7,
  parameter logic [WORD_W-1:0] CRC_RST_WORD = 32'hC0DE_0007,
  parameter logic [WORD_W-1:0] FIX_MASK     = 32'h0003_0000,
  parameter int                FIX_STRIDE   = 4,
  parameter int                FIX_PHASE    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen,
  input  logic              wb_start,
  input  logic              wb_brm,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [WORD_W-1:0] wb_data,
  output logic              wb_frame_done,
  output logic              busy
);
  import snap_pkg::*;

  localparam logic [IDX_W-1:0] W_LAST = IDX_W'(FRAME_WORDS - 1);

  emit_ph_e         ph;
  logic [IDX_W-1:0] widx;
  logic             brm_q;
  logic             fire;
  logic             start_ok;
  logic             last_w;

  function automatic logic [WORD_W-1:0] fix_mask(input logic [IDX_W-1:0] i);
    return word_patched(int'(i), FIX_STRIDE, FIX_PHASE) ? FIX_MASK : '0;
  endfunction

  assign start_ok = wb_start && frozen && (ph == EM_IDLE);
  assign last_w   = (widx == W_LAST);
  assign ld_ready = (ph == EM_DATA) && wb_ready;
  assign busy     = (ph != EM_IDLE);

  always_comb begin
    wb_valid = 1'b0;
    wb_data  = '0;
    case (ph)
      EM_DATA: begin
        wb_valid = ld_valid;
        wb_data  = brm_q ? (ld_data & ~fix_mask(widx)) : ld_data;
      end
      EM_PAD: wb_valid = 1'b1;
      EM_CMD: begin
        wb_valid = 1'b1;
        wb_data  = CRC_RST_WORD;
      end
      default: ;
    endcase
  end

  assign fire          = wb_valid && wb_ready;
  assign wb_frame_done = fire && (ph == EM_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= EM_IDLE;
      widx  <= '0;
      brm_q <= 1'b0;
    end else begin
      case (ph)
        EM_IDLE: if (start_ok) begin
          ph    <= EM_DATA;
          widx  <= '0;
          brm_q <= wb_brm;
        end
        EM_DATA, EM_PAD: if (fire) begin
          if (last_w) begin
            ph   <= (ph == EM_DATA) ? EM_PAD : EM_CMD;
            widx <= '0;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        EM_CMD: if (fire) ph <= EM_IDLE;
        default: ph <= EM_IDLE;
      endcase
    end
  end

  a_r7_cmd_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wb_frame_done |-> (wb_data == CRC_RST_WORD));
  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready && ph != EM_DATA) |=> $stable(wb_data));
  a_r9_load_needs_out: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> wb_ready);
  a_r11_start_needs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == EM_IDLE && !frozen) |=> (ph == EM_IDLE));

endmodule

// File: rtl/cfg_snap_fmt.sv
module cfg_snap_fmt #(
  parameter int                WORD_W       = 32,
  parameter int                FAR_W        = 32,
  parameter int                FRAME_WORDS  = 101,
  parameter int                IDX_W        = $clog2(FRAME_WORDS),
  parameter logic [WORD_W-1:0] CRC_RST_WORD = 32'hC0DE_0007,
  parameter logic [WORD_W-1:0] FIX_MASK     = 32'h0003_0000,
  parameter int                FIX_STRIDE   = 4,
  parameter int                FIX_PHASE    = 1,
  parameter int                GSR_LEN      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              resume_req,
  output logic              tenant_clk_en,
  output logic              gsr_pulse,
  input  logic              rb_valid,
  output logic              rb_ready,
  input  logic [WORD_W-1:0] rb_data,
  input  logic [FAR_W-1:0]  rb_frame_addr,
  output logic              rb_frame_done,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [WORD_W-1:0] st_data,
  output logic [IDX_W-1:0]  st_idx,
  output logic [FAR_W-1:0]  st_addr,
  input  logic              wb_start,
  input  logic              wb_brm,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [WORD_W-1:0] wb_data,
  output logic              wb_frame_done
);

  logic frozen;
  logic cap_busy;
  logic emit_busy;
  logic any_busy;

  assign any_busy = cap_busy || emit_busy;

  snap_clk_seq #(.GSR_LEN(GSR_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .resume_req(resume_req),
    .busy(any_busy), .frozen(frozen), .tenant_clk_en(tenant_clk_en),
    .gsr_pulse(gsr_pulse)
  );

  snap_capture #(
    .WORD_W(WORD_W), .FAR_W(FAR_W), .FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .frozen(frozen),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_data(rb_data),
    .rb_frame_addr(rb_frame_addr), .rb_frame_done(rb_frame_done),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .st_idx(st_idx), .st_addr(st_addr), .busy(cap_busy)
  );

  snap_emit #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W),
    .CRC_RST_WORD(CRC_RST_WORD), .FIX_MASK(FIX_MASK),
    .FIX_STRIDE(FIX_STRIDE), .FIX_PHASE(FIX_PHASE)
  ) u_emit (
    .clk(clk), .rst_n(rst_n), .frozen(frozen),
    .wb_start(wb_start), .wb_brm(wb_brm),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .wb_frame_done(wb_frame_done), .busy(emit_busy)
  );

  a_r1_no_transfer_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    tenant_clk_en |-> (!rb_ready && !st_valid));

endmodule

// File: tb/test_cfg_snap_fmt.sv
`timescale 1ns/1ps
module test_cfg_snap_fmt;

  localparam int FW = 101;
  localparam logic [31:0] CRC = 32'hC0DE_0007;
  localparam logic [31:0] MSK = 32'h0003_0000;
  localparam int GL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, resume_req = 0;
  logic tenant_clk_en, gsr_pulse;
  logic rb_valid = 0, rb_ready;
  logic [31:0] rb_data = '0, rb_frame_addr = '0;
  logic rb_frame_done;
  logic st_valid, st_ready = 1'b1;
  logic [31:0] st_data, st_addr;
  logic [6:0] st_idx;
  logic wb_start = 0, wb_brm = 0;
  logic ld_valid = 0, ld_ready;
  logic [31:0] ld_data = '0;
  logic wb_valid, wb_ready = 1'b1;
  logic [31:0] wb_data;
  logic wb_frame_done;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_snap_fmt i_cfg_snap_fmt (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .resume_req(resume_req),
    .tenant_clk_en(tenant_clk_en), .gsr_pulse(gsr_pulse),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_data(rb_data),
    .rb_frame_addr(rb_frame_addr), .rb_frame_done(rb_frame_done),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .st_idx(st_idx), .st_addr(st_addr),
    .wb_start(wb_start), .wb_brm(wb_brm),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .wb_frame_done(wb_frame_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rb_pat(input int f, input int i);
    return {8'(f), 8'hA5, 16'(i * 7 + 3)};
  endfunction

  function automatic logic [31:0] ld_pat(input int i);
    return 32'hFFFF_0000 | 32'(i);
  endfunction

  // positions 1, 5, 9, ... are patched in block-RAM frames
  function automatic logic [31:0] exp_wb(input bit brm, input int k);
    if (k >= 2 * FW) return CRC;
    if (k >= FW) return 32'h0;
    if (brm && k >= 1 && ((k - 1) / 4) * 4 == k - 1) return ld_pat(k) & ~MSK;
    return ld_pat(k);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rb_valid = 1'b1;
    #1;
    chk(tenant_clk_en == 1'b1, "R1 clk_en", 32'(tenant_clk_en), 1);
    chk(gsr_pulse == 1'b0, "R1 gsr", 32'(gsr_pulse), 0);
    chk(rb_ready == 1'b0, "R1 rb_ready", 32'(rb_ready), 0);
    chk(st_valid == 1'b0 && wb_valid == 1'b0, "R1 valids", 32'({st_valid, wb_valid}), 0);
    rb_valid = 1'b0;
  endtask

  task automatic t_ignore_running();
    @(negedge clk);
    rb_valid = 1'b1;
    wb_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wb_start = 1'b0;
    #1;
    chk(rb_ready == 1'b0 && st_valid == 1'b0, "R2 readback ignored while running",
        32'({rb_ready, st_valid}), 0);
    chk(wb_valid == 1'b0, "R11 start ignored while running", 32'(wb_valid), 0);
    rb_valid = 1'b0;
  endtask

  task automatic t_halt();
    @(negedge clk);
    halt_req = 1'b1;
    @(posedge clk);
    #1;
    chk(tenant_clk_en == 1'b0, "R2 halt stops clock", 32'(tenant_clk_en), 0);
    @(negedge clk);
    halt_req = 1'b0;
  endtask

  task automatic t_readback(input int f, input logic [31:0] far, input bit stall, input bit try_resume);
    for (int i = 0; i < 2 * FW; i++) begin
      @(negedge clk);
      if (try_resume && i == 30) begin
        rb_valid = 1'b0;
        resume_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resume_req = 1'b0;
        #1;
        chk(gsr_pulse == 1'b0 && tenant_clk_en == 1'b0, "R11 resume ignored mid-frame",
            32'({gsr_pulse, tenant_clk_en}), 0);
        @(negedge clk);
      end
      rb_valid = 1'b1;
      rb_data = (i < FW) ? 32'h0 : rb_pat(f, i - FW);
      rb_frame_addr = (i == 0) ? far : ~far;
      st_ready = !(stall && i < FW);
      if (stall && i >= FW && (i % 3) == 0) begin
        st_ready = 1'b0;
        #1;
        chk(rb_ready == 1'b0 && st_valid == 1'b1, "R6 data word waits for storage",
            32'({rb_ready, st_valid}), 32'b01);
        @(posedge clk);
        @(negedge clk);
        st_ready = 1'b1;
      end
      #1;
      chk(rb_ready == 1'b1, "R6 word accepted", 32'(rb_ready), 1);
      if (i >= FW) begin
        chk(st_valid == 1'b1 && st_data == rb_pat(f, i - FW), "R3 data forwarded", st_data, rb_pat(f, i - FW));
        chk(st_idx == 7'(i - FW), "R3 word index", 32'(st_idx), 32'(i - FW));
        chk(st_addr == far, "R4 frame tag", st_addr, far);
      end else begin
        chk(st_valid == 1'b0, "R3 padding dropped", 32'(st_valid), 0);
      end
      chk(rb_frame_done == (i == 2 * FW - 1), "R5 done pulse", 32'(rb_frame_done), 32'(i == 2 * FW - 1));
      @(posedge clk);
    end
    @(negedge clk);
    rb_valid = 1'b0;
    st_ready = 1'b1;
  endtask

  task automatic t_writeback(input bit brm, input bit stall);
    int k = 0;
    int cyc = 0;
    @(negedge clk);
    wb_start = 1'b1;
    wb_brm = brm;
    @(posedge clk);
    @(negedge clk);
    wb_start = 1'b0;
    wb_brm = !brm;
    while (k <= 2 * FW) begin
      ld_valid = (k < FW);
      ld_data = (k < FW) ? ld_pat(k) : 32'h0;
      wb_ready = !(stall && (cyc % 3) == 0);
      #1;
      chk(wb_valid == 1'b1, "R7 word valid", 32'(wb_valid), 1);
      chk(wb_data == exp_wb(brm, k), brm ? "R8 patched stream" : "R7 stream layout",
          wb_data, exp_wb(brm, k));
      if (!wb_ready) chk(ld_ready == 1'b0, "R9 no load while stalled", 32'(ld_ready), 0);
      else if (k < FW) chk(ld_ready == 1'b1, "R9 load taken", 32'(ld_ready), 1);
      chk(wb_frame_done == (wb_ready && k == 2 * FW), "R7 done pulse",
          32'(wb_frame_done), 32'(wb_ready && k == 2 * FW));
      @(posedge clk);
      if (wb_ready) k++;
      cyc++;
      @(negedge clk);
    end
    ld_valid = 1'b0;
    wb_ready = 1'b1;
    #1;
    chk(wb_valid == 1'b0, "R7 idle after command", 32'(wb_valid), 0);
  endtask

  task automatic t_resume();
    @(negedge clk);
    resume_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    resume_req = 1'b0;
    for (int c = 0; c < GL; c++) begin
      #1;
      chk(gsr_pulse == 1'b1 && tenant_clk_en == 1'b0, "R10 pulse with clock off",
          32'({gsr_pulse, tenant_clk_en}), 32'b10);
      @(negedge clk);
    end
    #1;
    chk(gsr_pulse == 1'b0 && tenant_clk_en == 1'b1, "R10 clock after pulse",
        32'({gsr_pulse, tenant_clk_en}), 32'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ignore_running();
    t_halt();
    t_readback(1, 32'h0040_1200, 1'b0, 1'b0);
    t_readback(2, 32'h0040_1301, 1'b1, 1'b1);
    t_writeback(1'b0, 1'b0);
    t_writeback(1'b1, 1'b1);
    t_resume();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule